// File: doc/BRIEF.md
# NAND ECC Segment Result Sequencer

This block sits beside a NAND data path. It watches every data beat that passes on the memory bus and keeps a running error-check code over one segment of a page at a time. A segment is a programmed number of bytes, or of 16-bit words when the block runs in wide mode. When a segment is complete, its code is written into the result slot that the slot pointer names. The pointer then moves to the next slot and the accumulator restarts from zero. There are nine slots. After the ninth is written the pointer parks past the end, the enable drops, and nothing more is gathered.

Software sets up the run through one configuration write. That write carries the starting slot, a clear strobe, two segment lengths, a per-slot length select, the bus width and the monitored chip select. A separate enable write then arms the run. Accumulation begins with the first beat on the chosen chip select and lasts until the final slot is filled or software disables the block. While a run is in progress, configuration writes are dropped. This lets a typical page layout be covered in one pass: eight slots of the long length for data, and one short slot for the spare area.

Top module: `nand_ecc_seq`

## Requirements
- R1: A beat is accumulated only when `beat_vld_i` is 1, `en_o` is 1, `beat_cs_i` equals the configured chip select and `ptr_o` is 1 to 9. Any other beat leaves the beat count, the running code, `ptr_o` and the results unchanged.
- R2: A slot result is 32 bits. Bits 15:0 are the XOR of all masked beat values in the segment. Bits 31:16 are the XOR of the zero-based beat index (zero-extended) of every beat whose masked value has odd parity.
- R3: The segment for slot j has size1 beats when `cfg_sel_i` bit j-1 was written 1, and size0 beats otherwise. On the edge that accepts the last beat, the result goes into slot j (`res_o` bits 32j-1 down to 32(j-1)), `ptr_o` becomes j+1, and the next segment starts from a zero code and count.
- R4: A configuration write loads the pointer with 0 turned into 1 and values above 10 turned into 10. `ptr_o` always reads 1 to 10 and resets to 1.
- R5: When slot 9 is written, `ptr_o` becomes 10 and `en_o` clears. While `ptr_o` is 10, `en_o` stays 0 even if enable is written 1.
- R6: An accepted configuration write with `cfg_clear_i` = 1 zeroes all nine results, the running code and the beat count. The strobe itself is not stored.
- R7: Segment sizes are stored clamped: below 2 becomes 2, above 512 becomes 512, and an odd value is rounded down to even. `size0_o` and `size1_o` reset to 2.
- R8: `busy_o` is 1 from the first accepted beat after enabling until `en_o` falls. While `busy_o` is 1, configuration writes are ignored entirely. Enable writes are accepted at any time.
- R9: With `cfg_wide_i` = 0, only bits 7:0 of a beat are used and bits 15:8 are treated as 0. With 1, all 16 bits are used.
- R10: If the final beat of slot 9 arrives in the same cycle as an enable write of 1, the freeze wins and `en_o` ends at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_clear_i | input | 1 | Clear request carried with the configuration write |
| cfg_ptr_i | input | 4 | Starting slot pointer |
| cfg_size0_i | input | 10 | Segment length 0 |
| cfg_size1_i | input | 10 | Segment length 1 |
| cfg_sel_i | input | 9 | Per-slot length select, bit j-1 for slot j |
| cfg_wide_i | input | 1 | 1 = 16-bit words, 0 = bytes |
| cfg_cs_i | input | 3 | Monitored chip select |
| en_we_i | input | 1 | Enable write strobe |
| en_wdata_i | input | 1 | Enable value to write |
| beat_vld_i | input | 1 | A data transfer (read or write) occurs this cycle |
| beat_cs_i | input | 3 | Chip select of the transfer |
| beat_data_i | input | 16 | Transfer data |
| ptr_o | output | 4 | Next slot to be written |
| en_o | output | 1 | Enable state |
| busy_o | output | 1 | Computation in progress |
| size0_o | output | 10 | Stored segment length 0 |
| size1_o | output | 10 | Stored segment length 1 |
| res_o | output | 288 | Nine 32-bit slot results, slot 1 in the low bits |

## Verification
Two events can land on the same edge. One is the completion of slot 9, which forces the freeze. The other is a software enable write of 1. The bench sets up a short final segment and drives its last beat together with the enable write. It then expects `ptr_o` = 10, `en_o` = 0 and `busy_o` = 0. Next it writes enable again and sends a further beat, and expects the stored slot 9 result to stay unchanged.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;
  localparam int LEN_W  = 10;
  localparam int SZ_MIN = 2;
  localparam int SZ_MAX = 512;

  typedef logic [LEN_W-1:0] len_t;

  function automatic len_t clamp_len(input len_t v);
    if (v < len_t'(SZ_MIN))      return len_t'(SZ_MIN);
    else if (v > len_t'(SZ_MAX)) return len_t'(SZ_MAX);
    else                         return {v[LEN_W-1:1], 1'b0};
  endfunction
endpackage

// File: rtl/nand_ecc_cfg.sv
module nand_ecc_cfg
  import nand_ecc_pkg::*;
#(
  parameter int NSLOT = 9,
  parameter int CSW   = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  len_t             size0_i,
  input  len_t             size1_i,
  input  logic [NSLOT-1:0] sel_i,
  input  logic             wide_i,
  input  logic [CSW-1:0]   cs_i,
  output len_t             size0_o,
  output len_t             size1_o,
  output logic [NSLOT-1:0] sel_o,
  output logic             wide_o,
  output logic [CSW-1:0]   cs_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      size0_o <= len_t'(SZ_MIN);
      size1_o <= len_t'(SZ_MIN);
      sel_o   <= '0;
      wide_o  <= 1'b0;
      cs_o    <= '0;
    end else if (we_i) begin
      size0_o <= clamp_len(size0_i);
      size1_o <= clamp_len(size1_i);
      sel_o   <= sel_i;
      wide_o  <= wide_i;
      cs_o    <= cs_i;
    end
  end

  p_size_legal_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !size0_o[0] && !size1_o[0] && size0_o >= len_t'(SZ_MIN) && size1_o >= len_t'(SZ_MIN)
    && size0_o <= len_t'(SZ_MAX) && size1_o <= len_t'(SZ_MAX));
endmodule

// File: rtl/nand_ecc_acc.sv
module nand_ecc_acc
  import nand_ecc_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            take_i,
  input  logic            clr_i,
  input  logic [DW-1:0]   data_i,
  input  len_t            len_i,
  output logic            done_o,
  output logic [2*DW-1:0] res_o
);
  len_t          cnt_q;
  logic [DW-1:0] col_q, row_q;
  logic [DW-1:0] col_nx, row_nx;
  len_t          cnt_nx;

  assign cnt_nx = cnt_q + 1'b1;
  // >= so a stale partial count can never run past a shorter length
  assign done_o = take_i && (cnt_nx >= len_i);
  assign col_nx = col_q ^ data_i;
  assign row_nx = row_q ^ ((^data_i) ? DW'(cnt_q) : '0);
  assign res_o  = {row_nx, col_nx};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      col_q <= '0;
      row_q <= '0;
    end else if (clr_i || done_o) begin
      cnt_q <= '0;
      col_q <= '0;
      row_q <= '0;
    end else if (take_i) begin
      cnt_q <= cnt_nx;
      col_q <= col_nx;
      row_q <= row_nx;
    end
  end

  p_cnt_cap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < len_t'(SZ_MAX));
  p_restart_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> cnt_q == '0);
endmodule

// File: rtl/nand_ecc_bank.sv
module nand_ecc_bank #(
  parameter int NSLOT = 9,
  parameter int RW    = 32,
  parameter int PW    = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clr_i,
  input  logic                wr_i,
  input  logic [PW-1:0]       idx_i,
  input  logic [RW-1:0]       data_i,
  output logic [NSLOT*RW-1:0] res_o
);
  for (genvar gi = 0; gi < NSLOT; gi++) begin : g_slot
    logic [RW-1:0] slot_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              slot_q <= '0;
      else if (clr_i)                           slot_q <= '0;
      else if (wr_i && idx_i == PW'(gi + 1))    slot_q <= data_i;
    end
    assign res_o[gi*RW +: RW] = slot_q;
  end
endmodule

// File: rtl/nand_ecc_seq.sv
module nand_ecc_seq
  import nand_ecc_pkg::*;
#(
  parameter  int NSLOT = 9,
  parameter  int DW    = 16,
  parameter  int CSW   = 3,
  localparam int PW    = $clog2(NSLOT + 2),
  localparam int RW    = 2 * DW
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cfg_we_i,
  input  logic                cfg_clear_i,
  input  logic [PW-1:0]       cfg_ptr_i,
  input  logic [LEN_W-1:0]    cfg_size0_i,
  input  logic [LEN_W-1:0]    cfg_size1_i,
  input  logic [NSLOT-1:0]    cfg_sel_i,
  input  logic                cfg_wide_i,
  input  logic [CSW-1:0]      cfg_cs_i,
  input  logic                en_we_i,
  input  logic                en_wdata_i,
  input  logic                beat_vld_i,
  input  logic [CSW-1:0]      beat_cs_i,
  input  logic [DW-1:0]       beat_data_i,
  output logic [PW-1:0]       ptr_o,
  output logic                en_o,
  output logic                busy_o,
  output logic [LEN_W-1:0]    size0_o,
  output logic [LEN_W-1:0]    size1_o,
  output logic [NSLOT*RW-1:0] res_o
);
  localparam int FROZEN = NSLOT + 1;

  logic [PW-1:0]    ptr_q, ptr_d, ptr_wr;
  logic             en_q, en_d, started_q;
  logic             cfg_ok, clr, take, done;
  len_t             size0_q, size1_q, seg_len;
  logic [NSLOT-1:0] sel_q;
  logic             wide_q;
  logic [CSW-1:0]   cs_q;
  logic [DW-1:0]    data_m;
  logic [RW-1:0]    seg_res;

  assign busy_o = en_q & started_q;
  assign cfg_ok = cfg_we_i & ~busy_o;
  assign clr    = cfg_ok & cfg_clear_i;

  nand_ecc_cfg #(.NSLOT(NSLOT), .CSW(CSW)) i_cfg (
    .clk_i, .rst_ni, .we_i(cfg_ok),
    .size0_i(cfg_size0_i), .size1_i(cfg_size1_i), .sel_i(cfg_sel_i),
    .wide_i(cfg_wide_i), .cs_i(cfg_cs_i),
    .size0_o(size0_q), .size1_o(size1_q), .sel_o(sel_q),
    .wide_o(wide_q), .cs_o(cs_q)
  );

  assign take   = beat_vld_i & en_q & (beat_cs_i == cs_q) & (ptr_q <= PW'(NSLOT));
  assign data_m = wide_q ? beat_data_i : {{(DW/2){1'b0}}, beat_data_i[DW/2-1:0]};

  always_comb begin
    seg_len = size0_q;
    for (int i = 0; i < NSLOT; i++)
      if (ptr_q == PW'(i + 1) && sel_q[i]) seg_len = size1_q;
  end

  nand_ecc_acc #(.DW(DW)) i_acc (
    .clk_i, .rst_ni, .take_i(take), .clr_i(clr), .data_i(data_m),
    .len_i(seg_len), .done_o(done), .res_o(seg_res)
  );

  nand_ecc_bank #(.NSLOT(NSLOT), .RW(RW), .PW(PW)) i_bank (
    .clk_i, .rst_ni, .clr_i(clr), .wr_i(done), .idx_i(ptr_q),
    .data_i(seg_res), .res_o(res_o)
  );

  assign ptr_wr = (cfg_ptr_i == '0)           ? PW'(1) :
                  (cfg_ptr_i > PW'(FROZEN))   ? PW'(FROZEN) : cfg_ptr_i;

  always_comb begin
    ptr_d = ptr_q;
    if (cfg_ok)    ptr_d = ptr_wr;
    else if (done) ptr_d = ptr_q + 1'b1;
    en_d = en_q;
    if (ptr_d == PW'(FROZEN)) en_d = 1'b0;   // freeze beats any enable write
    else if (en_we_i)         en_d = en_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q     <= PW'(1);
      en_q      <= 1'b0;
      started_q <= 1'b0;
    end else begin
      ptr_q     <= ptr_d;
      en_q      <= en_d;
      started_q <= en_d & (started_q | take);
    end
  end

  assign ptr_o   = ptr_q;
  assign en_o    = en_q;
  assign size0_o = size0_q;
  assign size1_o = size1_q;

  p_ptr_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_q >= PW'(1) && ptr_q <= PW'(FROZEN));
  p_frozen_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_q == PW'(FROZEN) |-> !en_q);
  p_advance_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && !cfg_we_i) |=> ptr_q == $past(ptr_q) + 1'b1);
  p_cfg_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && cfg_we_i) |=> $stable(size0_q) && $stable(size1_q) && $stable(cs_q) && $stable(wide_q));
  p_idle_beat_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_q && !cfg_we_i) |=> $stable(ptr_q) && $stable(res_o));
endmodule

// File: tb/test_nand_ecc_seq.sv
module test_nand_ecc_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 0, cfg_clear = 0, cfg_wide = 0;
  logic [3:0]  cfg_ptr = 0;
  logic [9:0]  cfg_s0 = 0, cfg_s1 = 0;
  logic [8:0]  cfg_sel = 0;
  logic [2:0]  cfg_cs = 0;
  logic        en_we = 0, en_wd = 0;
  logic        b_vld = 0;
  logic [2:0]  b_cs = 0;
  logic [15:0] b_data = 0;
  logic [3:0]  ptr;
  logic        en, busy;
  logic [9:0]  s0, s1;
  logic [287:0] res;

  int total = 0, bad = 0;
  logic [15:0] m_col, m_row;
  int          m_cnt;
  logic        m_wide;

  nand_ecc_seq i_nand_ecc_seq (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_clear_i(cfg_clear), .cfg_ptr_i(cfg_ptr),
    .cfg_size0_i(cfg_s0), .cfg_size1_i(cfg_s1), .cfg_sel_i(cfg_sel),
    .cfg_wide_i(cfg_wide), .cfg_cs_i(cfg_cs),
    .en_we_i(en_we), .en_wdata_i(en_wd),
    .beat_vld_i(b_vld), .beat_cs_i(b_cs), .beat_data_i(b_data),
    .ptr_o(ptr), .en_o(en), .busy_o(busy), .size0_o(s0), .size1_o(s1), .res_o(res)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 100000);
    total++; bad++;
    $display("FAIL watchdog: act=hung exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] slot(input int j);
    return res[(j-1)*32 +: 32];
  endfunction

  task automatic mdl_reset();
    m_col = '0; m_row = '0; m_cnt = 0;
  endtask

  task automatic mdl(input logic [15:0] d);
    logic [15:0] dm = m_wide ? d : {8'h00, d[7:0]};
    m_col ^= dm;
    if (^dm) m_row ^= 16'(m_cnt);
    m_cnt++;
  endtask

  task automatic cfg_wr(input logic [3:0] p, input logic c, input logic [9:0] a,
                        input logic [9:0] b, input logic [8:0] sl, input logic w,
                        input logic [2:0] cs);
    cfg_we = 1; cfg_clear = c; cfg_ptr = p; cfg_s0 = a; cfg_s1 = b;
    cfg_sel = sl; cfg_wide = w; cfg_cs = cs;
    @(negedge clk);
    cfg_we = 0; cfg_clear = 0;
  endtask

  task automatic en_wr(input logic v);
    en_we = 1; en_wd = v;
    @(negedge clk);
    en_we = 0;
  endtask

  task automatic beat(input logic [2:0] cs, input logic [15:0] d, input logic acc);
    b_vld = 1; b_cs = cs; b_data = d;
    if (acc) mdl(d);
    @(negedge clk);
    b_vld = 0;
  endtask

  task automatic t_reset();
    chk("R4 reset ptr", 32'(ptr), 1);
    chk("R5 reset en", 32'(en), 0);
    chk("R8 reset busy", 32'(busy), 0);
    chk("R6 reset results", 32'(|res), 0);
    chk("R7 reset size0", 32'(s0), 2);
  endtask

  task automatic t_clamp();
    cfg_wr(4'd0, 0, 10'd0, 10'd1023, '0, 0, 3'd0);
    chk("R4 ptr 0->1", 32'(ptr), 1);
    chk("R7 size 0->2", 32'(s0), 2);
    chk("R7 size 1023->512", 32'(s1), 512);
    cfg_wr(4'd12, 0, 10'd7, 10'd513, '0, 0, 3'd0);
    chk("R4 ptr 12->10", 32'(ptr), 10);
    chk("R7 size 7->6", 32'(s0), 6);
    chk("R7 size 513->512", 32'(s1), 512);
    cfg_wr(4'd3, 0, 10'd256, 10'd24, '0, 0, 3'd0);
    chk("R4 ptr 3", 32'(ptr), 3);
    chk("R7 size 256", 32'(s0), 256);
    chk("R7 size 24", 32'(s1), 24);
  endtask

  task automatic t_basic();
    cfg_wr(4'd1, 1, 10'd4, 10'd2, 9'b000000010, 1, 3'd2);
    m_wide = 1; mdl_reset();
    en_wr(1);
    beat(3'd2, 16'h1234, 1); beat(3'd2, 16'h0F0E, 1);
    chk("R8 busy after first beat", 32'(busy), 1);
    beat(3'd2, 16'h8001, 1); beat(3'd2, 16'h7777, 1);
    chk("R2 slot1 code", slot(1), {m_row, m_col});
    chk("R3 ptr after slot1", 32'(ptr), 2);
    mdl_reset();
    beat(3'd2, 16'hABCD, 1); beat(3'd2, 16'h0001, 1);
    chk("R3 slot2 uses size1", slot(2), {m_row, m_col});
    chk("R3 ptr after slot2", 32'(ptr), 3);
  endtask

  task automatic t_ignore();
    mdl_reset();
    beat(3'd5, 16'hFFFF, 0); beat(3'd0, 16'h1357, 0);
    b_cs = 3'd2; b_data = 16'hDEAD; @(negedge clk);   // valid low
    chk("R1 foreign beats no count", 32'(ptr), 3);
    beat(3'd2, 16'h0102, 1); beat(3'd5, 16'h4444, 0);
    beat(3'd2, 16'h00FF, 1); beat(3'd2, 16'hC001, 1);
    chk("R1 ptr held at 3 beats", 32'(ptr), 3);
    beat(3'd2, 16'h2468, 1);
    chk("R1 slot3 excludes foreign", slot(3), {m_row, m_col});
    chk("R1 ptr after slot3", 32'(ptr), 4);
  endtask

  task automatic t_busy();
    logic [31:0] keep = slot(1);
    mdl_reset();
    beat(3'd2, 16'h5A5A, 1);
    cfg_wr(4'd1, 1, 10'd8, 10'd8, 9'h000, 0, 3'd5);
    chk("R8 size0 held", 32'(s0), 4);
    chk("R8 ptr held", 32'(ptr), 4);
    chk("R8 clear ignored", slot(1), keep);
    beat(3'd2, 16'h1111, 1); beat(3'd2, 16'hF00F, 1); beat(3'd2, 16'h0300, 1);
    chk("R8 slot4 with old cfg", slot(4), {m_row, m_col});
    chk("R8 ptr after slot4", 32'(ptr), 5);
  endtask

  task automatic t_clear();
    beat(3'd2, 16'h9999, 0);            // partial, dropped by clear
    en_wr(0);
    chk("R8 idle after disable", 32'(busy), 0);
    cfg_wr(4'd1, 1, 10'd4, 10'd2, 9'h000, 1, 3'd2);
    chk("R6 results zeroed", 32'(|res), 0);
    en_wr(1); mdl_reset();
    beat(3'd2, 16'h0F00, 1); beat(3'd2, 16'h00F1, 1);
    beat(3'd2, 16'h3003, 1);
    chk("R6 no early finish", 32'(ptr), 1);
    beat(3'd2, 16'h8888, 1);
    chk("R6 fresh segment code", slot(1), {m_row, m_col});
  endtask

  task automatic t_byte();
    en_wr(0);
    cfg_wr(4'd1, 1, 10'd2, 10'd2, 9'h000, 0, 3'd3);
    en_wr(1); m_wide = 0; mdl_reset();
    beat(3'd3, 16'hA5C3, 1); beat(3'd3, 16'h7F01, 1);
    chk("R9 byte mode masks high byte", slot(1), {m_row, m_col});
  endtask

  task automatic t_freeze();
    logic [31:0] keep;
    en_wr(0);
    cfg_wr(4'd8, 1, 10'd2, 10'd4, 9'h100, 1, 3'd1);
    en_wr(1); m_wide = 1; mdl_reset();
    beat(3'd1, 16'h1000, 1); beat(3'd1, 16'h0007, 1);
    chk("R3 ptr to 9", 32'(ptr), 9);
    mdl_reset();
    beat(3'd1, 16'h0101, 1); beat(3'd1, 16'hFEED, 1); beat(3'd1, 16'h0002, 1);
    en_we = 1; en_wd = 1;
    beat(3'd1, 16'h4321, 1);
    en_we = 0;
    chk("R10 freeze beats enable write", 32'(en), 0);
    chk("R5 ptr frozen", 32'(ptr), 10);
    chk("R5 slot9 code", slot(9), {m_row, m_col});
    chk("R8 idle after freeze", 32'(busy), 0);
    keep = slot(9);
    en_wr(1);
    chk("R5 enable refused at 10", 32'(en), 0);
    beat(3'd1, 16'hFFFF, 0);
    chk("R5 slot9 kept", slot(9), keep);
    chk("R5 ptr still 10", 32'(ptr), 10);
  endtask

  initial begin
    m_wide = 1; mdl_reset();
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_clamp();
    t_basic();
    t_ignore();
    t_busy();
    t_clear();
    t_byte();
    t_freeze();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule